// File: doc/BRIEF.md
# Programmable Two-Level Sum-of-Products Array

This block evaluates a set of Boolean functions held in programmable form. Each product term is an AND of literals chosen from the inputs. Each output is the OR of the product terms connected to it. The functions are loaded through a small synchronous write port. The path from `dataIn` to `dataOut` is purely combinational and uses whatever configuration is stored at the time. No output is fed back into the array.

The `GENERAL` parameter picks one of two topologies. When it is nonzero, any term may drive any output, so one term can be shared by several functions. When it is zero, output `o` can only reach its own group of `GROUP` consecutive terms. In that mode a write that would connect a term from another group is refused, and a sticky flag records the refusal. Constrained mode requires `NUM_TERMS >= NUM_OUT * GROUP`.

Typical uses are code converters and small comparators. Examples are a BCD-to-Gray mapping, or EQ/NE/LT/GT for two 2-bit numbers. In these, a controller programs the rows once after reset and then streams input vectors through the array.

Top module: `sop_array`

## Requirements
- R1: An AND-plane row write (`cfgSel`=0) stores `cfgData[2*NUM_IN:0]` into term `cfgAddr`. Bit 2i asks for input i in true form and bit 2i+1 asks for it complemented. A term with neither bit set for input i ignores that input. A term with both bits set for the same input is always 0.
- R2: Bit 2*NUM_IN of a term row enables the term. A disabled term contributes 0 whatever its literals. An enabled term with no literals is a constant 1.
- R3: An OR-plane row write (`cfgSel`=1) stores `cfgData[NUM_TERMS-1:0]` as the connection mask of output `cfgAddr`, where bit t connects term t. Each output is the OR of its connected, true terms.
- R4: In general mode one term may be connected to several outputs at once, and every connected output sees it.
- R5: A write is taken at the rising edge where `cfgWe` is 1. From that edge on, `dataOut` reflects the new row combinationally. Without a write, `dataOut` depends only on `dataIn`.
- R6: Synchronous reset clears every row and the error flag, so `dataOut` is 0 for every input until the array is programmed.
- R7: In constrained mode, output o reaches only terms o*GROUP to o*GROUP+GROUP-1. An OR-plane write whose mask has any bit outside that group is dropped whole. The same write sets `cfgErr`, which stays 1 until reset.
- R8: In general mode `cfgErr` never becomes 1.
- R9: A write addressing a term at or above NUM_TERMS, or an output at or above NUM_OUT, changes nothing and does not set `cfgErr`.
- R10: Programmed with W = A + BD + BC, X = BC', Y = B + C and Z = A'B'C'D + BCD + AD' + B'CD', where A is `dataIn[3]` and W is `dataOut[3]`, digits 0 to 4 give 0000, 0001, 0011, 0010 and 0110. Digits 5 to 9 give the values of the same equations. Both topologies must produce this result.
- R11: Programmed as a comparator of AB (`dataIn[3:2]`) against CD (`dataIn[1:0]`), with shared terms, the outputs `dataOut[3:0]` give EQ, NE, LT and GT for all 16 inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Write enable for one configuration row |
| cfgSel | input | 1 | 0 selects a term row, 1 selects an output mask row |
| cfgAddr | input | ADDR_W | Term index or output index |
| cfgData | input | DATA_W | Row contents |
| dataIn | input | NUM_IN | Function inputs |
| dataOut | output | NUM_OUT | Function outputs |
| cfgErr | output | 1 | Sticky flag: a connection outside an output's group was refused |

## Verification
A corrupted stored term or mask can stay hidden until an input vector makes that term the only true term on one of its outputs. It then shows as a flipped output bit in the same cycle the vector is applied. For that reason the bench follows every configuration write with a fresh vector that is compared against a model of all stored rows, so a wrong row is normally caught within a few writes. A refused write that was stored anyway shows up either as a flipped output on the next matching vector or as `cfgErr` failing to rise at the edge that took the write.

// File: rtl/sop_pkg.sv
package sop_pkg;
  // Strobes from the write decoder to the storage/evaluation datapath
  typedef struct packed {
    logic andWr;   // store a product-term row
    logic orWr;    // store an output connection row
    logic errSet;  // a constrained write was refused
  } cfgStrobe_t;
endpackage

// File: rtl/sop_ctrl.sv
module sop_ctrl
  import sop_pkg::*;
#(
  parameter int NUM_TERMS = 16,
  parameter int NUM_OUT   = 4,
  parameter int GROUP     = 4,
  parameter bit GENERAL   = 1'b1,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  output cfgStrobe_t        strobe,
  output logic              cfgErr
);
  logic termAddrOk;
  logic outAddrOk;
  logic [NUM_TERMS-1:0] outsideBits;

  assign termAddrOk = int'(cfgAddr) < NUM_TERMS;
  assign outAddrOk  = int'(cfgAddr) < NUM_OUT;

  generate
    if (GENERAL) begin : g_free
      assign outsideBits = '0;
    end else begin : g_grouped
      logic [NUM_TERMS-1:0] grpMask;
      always_comb begin
        grpMask = '0;
        for (int t = 0; t < NUM_TERMS; t++) begin
          if ((t / GROUP) == int'(cfgAddr)) grpMask[t] = 1'b1;
        end
      end
      assign outsideBits = cfgData[NUM_TERMS-1:0] & ~grpMask;
    end
  endgenerate

  always_comb begin
    strobe.andWr  = cfgWe && !cfgSel && termAddrOk;
    strobe.orWr   = cfgWe && cfgSel && outAddrOk && (outsideBits == '0);
    strobe.errSet = cfgWe && cfgSel && outAddrOk && (outsideBits != '0);
  end

  always_ff @(posedge clk) begin
    if (rst)              cfgErr <= 1'b0;
    else if (strobe.errSet) cfgErr <= 1'b1;
  end
endmodule

// File: rtl/sop_datapath.sv
module sop_datapath
  import sop_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int NUM_TERMS = 16,
  parameter int NUM_OUT   = 4,
  parameter int GROUP     = 4,
  parameter bit GENERAL   = 1'b1,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  cfgStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgData,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] dataOut
);
  localparam int LIT_W = 2 * NUM_IN + 1;
  localparam int EN_B  = 2 * NUM_IN;

  logic [LIT_W-1:0]     andRow [NUM_TERMS];
  logic [NUM_TERMS-1:0] orRow  [NUM_OUT];
  logic [NUM_TERMS-1:0] termHit;

  // Configuration storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NUM_TERMS; t++) andRow[t] <= '0;
      for (int o = 0; o < NUM_OUT; o++)   orRow[o]  <= '0;
    end else begin
      for (int t = 0; t < NUM_TERMS; t++)
        if (strobe.andWr && int'(cfgAddr) == t) andRow[t] <= cfgData[LIT_W-1:0];
      for (int o = 0; o < NUM_OUT; o++)
        if (strobe.orWr && int'(cfgAddr) == o) orRow[o] <= cfgData[NUM_TERMS-1:0];
    end
  end

  // AND plane
  always_comb begin
    for (int t = 0; t < NUM_TERMS; t++) begin
      termHit[t] = andRow[t][EN_B];
      for (int i = 0; i < NUM_IN; i++) begin
        if (andRow[t][2*i] && !dataIn[i])    termHit[t] = 1'b0;
        if (andRow[t][2*i+1] && dataIn[i])   termHit[t] = 1'b0;
      end
    end
  end

  // OR plane: shared or grouped
  generate
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      if (GENERAL) begin : g_shared
        assign dataOut[o] = |(termHit & orRow[o]);
      end else begin : g_dedicated
        assign dataOut[o] = |(termHit[o*GROUP +: GROUP] & orRow[o][o*GROUP +: GROUP]);
      end
    end
  endgenerate
endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int NUM_TERMS = 16,
  parameter int NUM_OUT   = 4,
  parameter int GROUP     = 4,
  parameter bit GENERAL   = 1'b1,
  localparam int LIT_W    = 2 * NUM_IN + 1,
  localparam int DATA_W   = (LIT_W > NUM_TERMS) ? LIT_W : NUM_TERMS,
  localparam int ROWS     = (NUM_TERMS > NUM_OUT) ? NUM_TERMS : NUM_OUT,
  localparam int ADDR_W   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgWe,
  input  logic               cfgSel,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgData,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] dataOut,
  output logic               cfgErr
);
  cfgStrobe_t strobe;

  sop_ctrl #(
    .NUM_TERMS(NUM_TERMS), .NUM_OUT(NUM_OUT), .GROUP(GROUP),
    .GENERAL(GENERAL), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .strobe(strobe), .cfgErr(cfgErr)
  );

  sop_datapath #(
    .NUM_IN(NUM_IN), .NUM_TERMS(NUM_TERMS), .NUM_OUT(NUM_OUT), .GROUP(GROUP),
    .GENERAL(GENERAL), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk
  import sop_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4,
  parameter bit GENERAL = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_IN-1:0]  dataIn,
  input logic [NUM_OUT-1:0] dataOut,
  input logic               cfgErr,
  input cfgStrobe_t         strobe
);
  logic seenEdge = 1'b0;
  always_ff @(posedge clk) seenEdge <= 1'b1;

  AST_RESET_QUIET: assert property (@(posedge clk)
    (seenEdge && $past(rst)) |-> (dataOut == '0 && !cfgErr)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfgErr |=> cfgErr); // R7

  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (rst)
    strobe.errSet |=> cfgErr); // R7

  AST_GENERAL_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (GENERAL != 1'b0) |-> (!cfgErr && !strobe.errSet)); // R8

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(strobe.andWr || strobe.orWr) |=> (!$stable(dataIn) || $stable(dataOut))); // R5

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.andWr, strobe.orWr, strobe.errSet})); // R9
endmodule

bind sop_array sop_array_chk #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .GENERAL(GENERAL)
) u_chk (
  .clk(clk), .rst(rst), .dataIn(dataIn), .dataOut(dataOut),
  .cfgErr(cfgErr), .strobe(strobe)
);

// File: tb/sop_array_bench.sv
module sop_array_bench;
  localparam int CLK_NS = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic weG = 1'b0, weC = 1'b0, sel = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] data = '0;
  logic [3:0]  din  = '0;
  logic [3:0]  outG, outC;
  logic        errG, errC;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // Models of stored rows
  logic [15:0][8:0] gAnd, cAnd;
  logic [3:0][15:0] gOr, cOr;
  logic cErrExp;

  always #(CLK_NS/2) clk = ~clk;

  sop_array #(.GENERAL(1'b1)) u_sop_array (
    .clk(clk), .rst(rst), .cfgWe(weG), .cfgSel(sel), .cfgAddr(addr),
    .cfgData(data), .dataIn(din), .dataOut(outG), .cfgErr(errG));

  sop_array #(.GENERAL(1'b0)) u_sop_array_fixed (
    .clk(clk), .rst(rst), .cfgWe(weC), .cfgSel(sel), .cfgAddr(addr),
    .cfgData(data), .dataIn(din), .dataOut(outC), .cfgErr(errC));

  function automatic logic [3:0] evalModel(input logic [15:0][8:0] a,
                                           input logic [3:0][15:0] o,
                                           input logic [3:0] x);
    logic [15:0] hit;
    logic [3:0] r;
    for (int t = 0; t < 16; t++) begin
      hit[t] = a[t][8];
      for (int i = 0; i < 4; i++)
        if ((a[t][2*i] && !x[i]) || (a[t][2*i+1] && x[i])) hit[t] = 1'b0;
    end
    for (int k = 0; k < 4; k++) r[k] = |(hit & o[k]);
    return r;
  endfunction

  function automatic logic [15:0] term(input logic [3:0] tr, input logic [3:0] cp);
    logic [15:0] v = 16'h0100;
    for (int i = 0; i < 4; i++) begin
      v[2*i] = tr[i];
      v[2*i+1] = cp[i];
    end
    return v;
  endfunction

  function automatic logic [3:0] grayRef(input logic [3:0] x);
    logic a, b, c, d;
    {a, b, c, d} = x;
    return {a | (b & d) | (b & c), b & ~c, b | c,
            (~a & ~b & ~c & d) | (b & c & d) | (a & ~d) | (~b & c & ~d)};
  endfunction

  function automatic logic [3:0] cmpRef(input logic [3:0] x);
    return {x[3:2] == x[1:0], x[3:2] != x[1:0], x[3:2] < x[1:0], x[3:2] > x[1:0]};
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clearModels();
    gAnd = '0; cAnd = '0; gOr = '0; cOr = '0; cErrExp = 1'b0;
  endtask

  task automatic wr(input bit toG, input bit toC, input logic s,
                    input logic [3:0] a, input logic [15:0] d);
    logic [15:0] grp;
    @(negedge clk);
    weG = toG; weC = toC; sel = s; addr = a; data = d;
    @(negedge clk);
    weG = 1'b0; weC = 1'b0;
    if (toG) begin
      if (!s) gAnd[a] = d[8:0];
      else if (a < 4) gOr[a] = d;
    end
    if (toC) begin
      if (!s) cAnd[a] = d[8:0];
      else if (a < 4) begin
        grp = 16'h000F << (4 * a);
        if ((d & ~grp) != 0) cErrExp = 1'b1;
        else cOr[a] = d;
      end
    end
  endtask

  task automatic applyBoth(input string req, input logic [3:0] x);
    din = x;
    #2;
    check(req, {errG, outG}, {1'b0, evalModel(gAnd, gOr, x)});
    check(req, {errC, outC}, {cErrExp, evalModel(cAnd, cOr, x)});
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    clearModels();
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog expired");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    clearModels();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R6: cleared array reads 0 for every input
    for (int x = 0; x < 16; x++) begin
      din = 4'(x); #2;
      check("R6 reset", {errG, outG, errC, outC}[4:0], 5'b0);
      check("R6 reset general", {errG, outG}, 5'b0);
    end

    // R2: enabled term without literals is constant 1; disabled is 0
    wr(1, 1, 1'b0, 4'd0, 16'h0100);
    wr(1, 1, 1'b1, 4'd0, 16'h0001);
    din = 4'hA; #2;
    check("R2 empty enabled term", {1'b0, outG}, 5'b00001);
    wr(1, 1, 1'b0, 4'd0, 16'h0000);
    din = 4'h5; #2;
    check("R2 disabled term", {1'b0, outG}, 5'b0);
    // R1: true and complement of one input together is always 0
    wr(1, 1, 1'b0, 4'd0, 16'h0103);
    for (int x = 0; x < 16; x++) applyBoth("R1 contradictory literals", 4'(x));

    // R10: Gray conversion, general array with terms t0..t9
    doReset();
    wr(1, 0, 0, 4'd0, term(4'b1000, 4'b0000));
    wr(1, 0, 0, 4'd1, term(4'b0101, 4'b0000));
    wr(1, 0, 0, 4'd2, term(4'b0110, 4'b0000));
    wr(1, 0, 0, 4'd3, term(4'b0100, 4'b0010));
    wr(1, 0, 0, 4'd4, term(4'b0100, 4'b0000));
    wr(1, 0, 0, 4'd5, term(4'b0010, 4'b0000));
    wr(1, 0, 0, 4'd6, term(4'b0001, 4'b1110));
    wr(1, 0, 0, 4'd7, term(4'b0111, 4'b0000));
    wr(1, 0, 0, 4'd8, term(4'b1000, 4'b0001));
    wr(1, 0, 0, 4'd9, term(4'b0010, 4'b0101));
    wr(1, 0, 1, 4'd3, 16'h0007);
    wr(1, 0, 1, 4'd2, 16'h0008);
    wr(1, 0, 1, 4'd1, 16'h0030);
    wr(1, 0, 1, 4'd0, 16'h03C0);
    // Constrained array: each output uses its own group
    wr(0, 1, 0, 4'd12, term(4'b1000, 4'b0000));
    wr(0, 1, 0, 4'd13, term(4'b0101, 4'b0000));
    wr(0, 1, 0, 4'd14, term(4'b0110, 4'b0000));
    wr(0, 1, 0, 4'd8,  term(4'b0100, 4'b0010));
    wr(0, 1, 0, 4'd4,  term(4'b0100, 4'b0000));
    wr(0, 1, 0, 4'd5,  term(4'b0010, 4'b0000));
    wr(0, 1, 0, 4'd0,  term(4'b0001, 4'b1110));
    wr(0, 1, 0, 4'd1,  term(4'b0111, 4'b0000));
    wr(0, 1, 0, 4'd2,  term(4'b1000, 4'b0001));
    wr(0, 1, 0, 4'd3,  term(4'b0010, 4'b0101));
    wr(0, 1, 1, 4'd3, 16'h7000);
    wr(0, 1, 1, 4'd2, 16'h0100);
    wr(0, 1, 1, 4'd1, 16'h0030);
    wr(0, 1, 1, 4'd0, 16'h000F);
    begin
      logic [3:0] first [5] = '{4'b0000, 4'b0001, 4'b0011, 4'b0010, 4'b0110};
      for (int d = 0; d < 10; d++) begin
        din = 4'(d); #2;
        if (d < 5) begin
          check("R10 gray general", {1'b0, outG}, {1'b0, first[d]});
          check("R10 gray constrained", {errC, outC}, {1'b0, first[d]});
        end
        check("R10 gray general eq", {errG, outG}, {1'b0, grayRef(4'(d))});
        check("R10 gray constrained eq", {errC, outC}, {1'b0, grayRef(4'(d))});
      end
    end

    // R7: cross-group connection refused, flag sticky, outputs unchanged
    wr(0, 1, 1, 4'd1, 16'h0031);
    for (int d = 0; d < 10; d++) begin
      din = 4'(d); #2;
      check("R7 refused write", {errC, outC}, {1'b1, grayRef(4'(d))});
    end
    wr(0, 1, 1, 4'd1, 16'h0030);
    din = 4'd4; #2;
    check("R7 sticky flag", {errC, outC}, {1'b1, grayRef(4'd4)});

    // R9: out-of-range output row changes nothing, no flag on the general array
    wr(1, 0, 1, 4'd9, 16'hFFFF);
    for (int x = 0; x < 16; x++) applyBoth("R9 out-of-range", 4'(x));

    // R11 and R4: comparator with shared terms (t4 -> NE,GT; t5 -> NE,LT)
    doReset();
    wr(1, 0, 0, 4'd0,  term(4'b0000, 4'b1111));
    wr(1, 0, 0, 4'd1,  term(4'b0101, 4'b1010));
    wr(1, 0, 0, 4'd2,  term(4'b1111, 4'b0000));
    wr(1, 0, 0, 4'd3,  term(4'b1010, 4'b0101));
    wr(1, 0, 0, 4'd4,  term(4'b1000, 4'b0010));
    wr(1, 0, 0, 4'd5,  term(4'b0010, 4'b1000));
    wr(1, 0, 0, 4'd6,  term(4'b0001, 4'b0100));
    wr(1, 0, 0, 4'd7,  term(4'b0100, 4'b0001));
    wr(1, 0, 0, 4'd10, term(4'b0001, 4'b1100));
    wr(1, 0, 0, 4'd11, term(4'b0011, 4'b0100));
    wr(1, 0, 0, 4'd12, term(4'b0100, 4'b0011));
    wr(1, 0, 0, 4'd13, term(4'b1100, 4'b0001));
    wr(1, 0, 1, 4'd3, 16'h000F);
    wr(1, 0, 1, 4'd2, 16'h00F0);
    wr(1, 0, 1, 4'd1, 16'h0C20);
    wr(1, 0, 1, 4'd0, 16'h3010);
    for (int x = 0; x < 16; x++) begin
      din = 4'(x); #2;
      check("R11 comparator R4 shared", {errG, outG}, {1'b0, cmpRef(4'(x))});
    end

    // R3 R5 R8: random rows mixed with vectors, both topologies
    doReset();
    for (int n = 0; n < 400; n++) begin
      logic s;
      logic [3:0] a;
      logic [15:0] d;
      s = 1'($urandom);
      a = 4'($urandom % 16);
      d = 16'($urandom);
      if (s && a < 4 && ($urandom % 4) != 0) d = (d & 16'h000F) << (4 * a);
      wr(1, 1, s, a, d);
      applyBoth("R3 R5 R8 random", 4'($urandom));
      applyBoth("R3 random", 4'($urandom));
    end

    // R6: mid-run reset clears rows and flag
    doReset();
    for (int x = 0; x < 16; x++) applyBoth("R6 mid-run reset", 4'(x));

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
    $finish;
  end
endmodule